// File: doc/BRIEF.md
# Trap Call and Return Sequencer

This block is the control sequencer that carries out a software trap instruction and the matching return. A trap carries an 8-bit vector number. The sequencer performs four steps. It writes the return address into the fixed link register of the register file. It then reads one word from a table of service-routine start addresses in low memory, using the vector as the index. It waits for that read to finish. Finally it loads the fetched word into the program counter. Each table entry holds an address, not code.

A return instruction skips the table. It copies the link register straight into the program counter. The enclosing core supplies the decoded request pulses, the vector and the already-incremented PC. It gives the sequencer one register-file write port, one read port and a single-word memory read handshake. The core stalls while `busy` is high.

Top module: `trap_seq`

## Requirements
- R1: After reset, `busy`, `rf_we`, `mem_req` and `pc_we` are all low.
- R2: A trap request (`trap_req` high) that is sampled at a clock edge while the block is idle is accepted. In the following cycle `rf_we` is high for exactly one cycle, with `rf_waddr` equal to the link register index (7) and `rf_wdata` equal to the `pc_cur` value sampled at the accepting edge.
- R3: In the cycle after the link write, `mem_req` is high for exactly one cycle. `mem_addr` then equals the accepted vector zero-extended to 16 bits, so it always lies in x0000 to x00FF; vector x25 gives x0025.
- R4: After the request, the block waits any number of cycles for `mem_ack`. In the cycle after `mem_ack` is sampled high, `pc_we` is high with `pc_wdata` equal to the `mem_rdata` sampled with that acknowledge.
- R5: A return request (`ret_req` high with `trap_req` low) that is sampled while idle makes `pc_we` high in the next cycle. `pc_wdata` then equals the `rf_rdata` sampled at the accepting edge. A return raises neither `rf_we` nor `mem_req`, and `rf_raddr` is always 7.
- R6: `busy` is high from the cycle after acceptance through the cycle in which `pc_we` is high, and low in the cycle after that.
- R7: While `busy` is high, new trap and return requests are ignored. No extra write occurs, and the saved PC and vector of the running trap are unchanged.
- R8: When `trap_req` and `ret_req` are both high at an idle edge, the trap is taken.
- R9: `pc_we` is high for exactly one cycle per accepted request. A `mem_ack` arriving outside the wait for the table read has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Decoded trap instruction |
| ret_req | input | 1 | Decoded return instruction |
| trap_vec | input | 8 | Trap vector number |
| pc_cur | input | 16 | Address of the instruction after the trap |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 3 | Register-file write index |
| rf_wdata | output | 16 | Register-file write data |
| rf_raddr | output | 3 | Register-file read index (link register) |
| rf_rdata | input | 16 | Register-file read data |
| mem_req | output | 1 | Table read request, one cycle |
| mem_addr | output | 16 | Table entry address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data |
| pc_we | output | 1 | Program counter load enable |
| pc_wdata | output | 16 | New program counter value |
| busy | output | 1 | Sequence in progress |

## Verification
Traps are driven with the edge vectors x00 and xFF, the service vectors x20 through x25, and random vectors. Each is paired with a memory latency from zero to several wait cycles, which shows whether the target comes from the acknowledged word rather than from a stale or early value. Returns use random link contents that change right after acceptance, which separates a sampled target from a live one. Busy-time noise changes the PC, the vector and both requests, and simultaneous trap and return requests plus stray acknowledges while idle check that only the accepted instruction shapes the outputs.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SAVE_LINK,
      ST_READ_VEC,
      ST_WAIT_MEM,
      ST_LOAD_PC
   } seq_state_e;
endpackage

// File: rtl/trap_seq_fsm.sv
module trap_seq_fsm
   import trap_seq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic trap_req,
   input  logic ret_req,
   input  logic mem_ack,
   output logic accept_trap,
   output logic accept_ret,
   output logic take_ack,
   output logic link_we,
   output logic vec_req,
   output logic pc_load,
   output logic busy
);
   seq_state_e state_q, state_d;

   assign accept_trap = (state_q == ST_IDLE) && trap_req;
   assign accept_ret  = (state_q == ST_IDLE) && !trap_req && ret_req;
   assign take_ack    = (state_q == ST_WAIT_MEM) && mem_ack;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (accept_trap)     state_d = ST_SAVE_LINK;
            else if (accept_ret) state_d = ST_LOAD_PC;
         end
         ST_SAVE_LINK: state_d = ST_READ_VEC;
         ST_READ_VEC:  state_d = ST_WAIT_MEM;
         ST_WAIT_MEM:  if (mem_ack) state_d = ST_LOAD_PC;
         ST_LOAD_PC:   state_d = ST_IDLE;
         default:      state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign link_we = (state_q == ST_SAVE_LINK);
   assign vec_req = (state_q == ST_READ_VEC);
   assign pc_load = (state_q == ST_LOAD_PC);
   assign busy    = (state_q != ST_IDLE);

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!link_we && !vec_req && !pc_load));
   a_r2_link_then_read: assert property (@(posedge clk) disable iff (!rst_n)
      link_we |=> vec_req);
   a_r3_req_single: assert property (@(posedge clk) disable iff (!rst_n)
      vec_req |=> !vec_req);
   a_r6_load_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |-> busy);
   a_r6_release_after_load: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |=> !busy);
   a_r7_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !pc_load) |=> busy);
   a_r9_load_single: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |=> !pc_load);
endmodule

// File: rtl/trap_seq_vecaddr.sv
module trap_seq_vecaddr #(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned VEC_W      = 8,
   parameter int unsigned TABLE_BASE = 0
) (
   input  logic [VEC_W-1:0]  vec,
   output logic [ADDR_W-1:0] entry_addr
);
   localparam int unsigned PAD_W = ADDR_W - VEC_W;

   generate
      if (VEC_W >= ADDR_W) begin : g_bad_width
         $error("vector must be narrower than the address");
      end
      if (TABLE_BASE == 0) begin : g_zero_base
         assign entry_addr = {{PAD_W{1'b0}}, vec};
      end else begin : g_offset_base
         if ((TABLE_BASE % (1 << VEC_W)) != 0) begin : g_bad_base
            $error("table base must be aligned to the table size");
         end
         assign entry_addr = ADDR_W'(TABLE_BASE) | {{PAD_W{1'b0}}, vec};
      end
   endgenerate
endmodule

// File: rtl/trap_seq_hold.sv
module trap_seq_hold #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned VEC_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept_trap,
   input  logic              accept_ret,
   input  logic              take_ack,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [VEC_W-1:0]  vec_in,
   input  logic [ADDR_W-1:0] link_in,
   input  logic [ADDR_W-1:0] mem_data,
   output logic [ADDR_W-1:0] saved_pc,
   output logic [VEC_W-1:0]  saved_vec,
   output logic [ADDR_W-1:0] target
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         saved_pc  <= '0;
         saved_vec <= '0;
         target    <= '0;
      end else begin
         if (accept_trap) begin
            saved_pc  <= pc_in;
            saved_vec <= vec_in;
         end
         if (accept_ret)    target <= link_in;
         else if (take_ack) target <= mem_data;
      end
   end
endmodule

// File: rtl/trap_seq.sv
module trap_seq #(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned VEC_W      = 8,
   parameter int unsigned REG_IDX_W  = 3,
   parameter int unsigned LINK_REG   = 7,
   parameter int unsigned TABLE_BASE = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 trap_req,
   input  logic                 ret_req,
   input  logic [VEC_W-1:0]     trap_vec,
   input  logic [ADDR_W-1:0]    pc_cur,
   output logic                 rf_we,
   output logic [REG_IDX_W-1:0] rf_waddr,
   output logic [ADDR_W-1:0]    rf_wdata,
   output logic [REG_IDX_W-1:0] rf_raddr,
   input  logic [ADDR_W-1:0]    rf_rdata,
   output logic                 mem_req,
   output logic [ADDR_W-1:0]    mem_addr,
   input  logic                 mem_ack,
   input  logic [ADDR_W-1:0]    mem_rdata,
   output logic                 pc_we,
   output logic [ADDR_W-1:0]    pc_wdata,
   output logic                 busy
);
   localparam logic [REG_IDX_W-1:0] LINK_IDX = REG_IDX_W'(LINK_REG);

   generate
      if (LINK_REG >= (1 << REG_IDX_W)) begin : g_bad_link
         $error("link register index out of range");
      end
   endgenerate

   logic accept_trap, accept_ret, take_ack;
   logic [ADDR_W-1:0] saved_pc, target;
   logic [VEC_W-1:0]  saved_vec;

   trap_seq_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .ret_req(ret_req),
      .mem_ack(mem_ack), .accept_trap(accept_trap), .accept_ret(accept_ret),
      .take_ack(take_ack), .link_we(rf_we), .vec_req(mem_req),
      .pc_load(pc_we), .busy(busy)
   );

   trap_seq_hold #(.ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .accept_trap(accept_trap),
      .accept_ret(accept_ret), .take_ack(take_ack), .pc_in(pc_cur),
      .vec_in(trap_vec), .link_in(rf_rdata), .mem_data(mem_rdata),
      .saved_pc(saved_pc), .saved_vec(saved_vec), .target(target)
   );

   trap_seq_vecaddr #(.ADDR_W(ADDR_W), .VEC_W(VEC_W), .TABLE_BASE(TABLE_BASE)) u_addr (
      .vec(saved_vec), .entry_addr(mem_addr)
   );

   assign rf_waddr = LINK_IDX;
   assign rf_raddr = LINK_IDX;
   assign rf_wdata = saved_pc;
   assign pc_wdata = target;

   a_r2_link_index: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> (rf_waddr == LINK_IDX));
   a_r2_pc_captured: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && trap_req) |=> (rf_we && rf_wdata == $past(pc_cur)));
   a_r3_addr_in_table: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> ((mem_addr >> VEC_W) == (ADDR_W'(TABLE_BASE) >> VEC_W)));
   a_r4_ack_to_pc: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !mem_req && !rf_we && !pc_we && mem_ack)
      |=> (pc_we && pc_wdata == $past(mem_rdata)));
   a_r5_ret_to_pc: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !trap_req && ret_req) |=> (pc_we && pc_wdata == $past(rf_rdata)));
   a_r7_stable_link: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !pc_we) |=> $stable(rf_wdata));
endmodule

// File: tb/trap_seq_test.sv
module trap_seq_test;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic trap_req = 0, ret_req = 0, mem_ack = 0;
   logic [7:0]  trap_vec = '0;
   logic [15:0] pc_cur = '0, rf_rdata = '0, mem_rdata = '0;
   logic rf_we, mem_req, pc_we, busy;
   logic [2:0] rf_waddr, rf_raddr;
   logic [15:0] rf_wdata, mem_addr, pc_wdata;

   int checks = 0, failures = 0;
   bit timed_out = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   trap_seq uut (
      .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .ret_req(ret_req),
      .trap_vec(trap_vec), .pc_cur(pc_cur), .rf_we(rf_we), .rf_waddr(rf_waddr),
      .rf_wdata(rf_wdata), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata), .pc_we(pc_we), .pc_wdata(pc_wdata), .busy(busy)
   );

   function automatic logic [15:0] table_word(input logic [7:0] v);
      return 16'h0400 + {8'h00, v} * 16'h0031 ^ 16'h5A00;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic run_trap(input logic [7:0] v, input logic [15:0] pc, input int lat,
                           input bit noise, input bit with_ret);
      logic [15:0] w;
      w = table_word(v);
      @(negedge clk);
      trap_req = 1; ret_req = with_ret; trap_vec = v; pc_cur = pc;
      rf_rdata = ~pc;
      @(negedge clk);
      trap_req = 0; ret_req = 0;
      check("R2 link write", {rf_we, rf_waddr}, {1'b1, 3'd7});
      check("R2 link data", rf_wdata, pc);
      check("R8 trap wins", pc_we, 0);
      check("R6 busy", busy, 1);
      if (noise) begin
         trap_req = 1; ret_req = 1; trap_vec = ~v; pc_cur = pc ^ 16'hFFFF;
      end
      @(negedge clk);
      check("R3 req", {mem_req, rf_we}, {1'b1, 1'b0});
      check("R3 addr", mem_addr, {8'h00, v});
      if (noise) check("R7 link held", rf_wdata, pc);
      for (int i = 0; i < lat; i++) begin
         @(negedge clk);
         check("R4 waiting", {mem_req, pc_we, busy, rf_we}, 4'b0010);
      end
      @(negedge clk);
      check("R4 no early load", pc_we, 0);
      mem_ack = 1; mem_rdata = w;
      @(negedge clk);
      mem_ack = 0; mem_rdata = 16'hDEAD;
      check("R4 pc load", {pc_we, pc_wdata}, {1'b1, w});
      check("R6 busy at load", busy, 1);
      @(negedge clk);
      check("R6 idle after", busy, 0);
      check("R9 single load", pc_we, 0);
      check("R7 no extra write", {rf_we, mem_req}, 0);
      trap_req = 0; ret_req = 0;
   endtask

   task automatic run_ret(input logic [15:0] link);
      @(negedge clk);
      ret_req = 1; rf_rdata = link;
      @(negedge clk);
      ret_req = 0; rf_rdata = ~link;
      check("R5 pc load", {pc_we, pc_wdata}, {1'b1, link});
      check("R5 no side effects", {rf_we, mem_req, rf_raddr}, {2'b00, 3'd7});
      check("R6 busy at load", busy, 1);
      @(negedge clk);
      check("R6 idle after", busy, 0);
      check("R9 single load", pc_we, 0);
   endtask

   task automatic run_all();
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check("R1 reset", {busy, rf_we, mem_req, pc_we}, 0);
      rst_n = 1;
      @(negedge clk);
      check("R1 after release", {busy, rf_we, mem_req, pc_we}, 0);
      mem_ack = 1; mem_rdata = 16'hBEEF;
      @(negedge clk);
      mem_ack = 0;
      @(negedge clk);
      check("R9 stray ack", {pc_we, busy}, 0);
      run_trap(8'h00, 16'h3001, 0, 0, 0);
      run_trap(8'hFF, 16'hFDFF, 3, 0, 0);
      for (int v = 8'h20; v <= 8'h25; v++)
         run_trap(8'(v), 16'h3000 + 16'(v), v - 8'h20, 0, 0);
      run_trap(8'h25, 16'h4123, 1, 1, 0);
      run_trap(8'h21, 16'h5000, 2, 0, 1);
      run_ret(16'h3456);
      run_ret(16'h0000);
      for (int n = 0; n < 40; n++) begin
         if ($urandom_range(0, 2) == 0) run_ret(16'($urandom));
         else run_trap(8'($urandom), 16'($urandom), int'($urandom_range(0, 4)),
                       bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
      end
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (WATCHDOG) @(posedge clk);
            timed_out = 1;
         end
      join_any
      disable fork;
      if (timed_out) begin
         checks++; failures++;
         $display("FAIL watchdog actual=expired expected=done");
      end
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule